// File: doc/BRIEF.md
# Vertical Divider Sync Controller

This block decides when each video field starts and when the vertical drive pulse is issued. It is clocked by a fast system clock and advances only on a half-line enable, which arrives twice per video line. A line counter measures half-lines since the last field start. A saturating confidence counter records whether recent separated vertical sync pulses arrived at the expected position. The state machine then picks one of three ways to end each field. It can free-run as a flywheel, it can accept a pulse only inside a narrow window, or it can accept any pulse and otherwise time out.

The controller keeps a field side, either 50 Hz or 60 Hz. Every count limit and window depends on the side. The side can be forced by two mode inputs. Otherwise it is chosen from where incoming pulses fall, with a fallback when none arrive. The vertical drive output is a short pulse at the start of every field, and its output enable is removed in search-tuning mode.

States are COUNT (code 0, early part of a field), NORM (1, flywheel), NEAR (2, windowed), NONORM (3, open search) and WAIT (4, one half-line before a flywheel field restarts). The transitions are: COUNT to NORM, NEAR or NONORM at the decision count; NORM to WAIT at the flywheel end; WAIT to COUNT; NEAR to COUNT on a windowed pulse or at fallback; NONORM to COUNT on any pulse or at timeout.

Top module: `vdiv_ctrl`

## Requirements
- R1: State, line counter and outputs change only on clock edges where `hl_en` is 1. Each such edge advances the line counter by one unless the counter is cleared.
- R2: In COUNT, the enable seen with line count 488 moves the controller by confidence level: 3 goes to NORM, 2 goes to NEAR, 0 or 1 goes to NONORM. `ctl_state` encodings are COUNT=0, NORM=1, NEAR=2, NONORM=3, WAIT=4.
- R3: NORM ignores sync for timing. At count 626 (50 Hz) or 526 (60 Hz) it enters WAIT, and the next enable clears the counter into COUNT. This gives fields of 628 or 528 half-lines.
- R4: NEAR returns to COUNT on a sync pulse start with 622 < count < 628 (50 Hz) or 522 < count < 528 (60 Hz), and clears the counter one half-line later. With no such pulse, it returns at count 628 or 528 and clears at once.
- R5: NONORM returns to COUNT on any sync pulse start and clears the counter one half-line later. With no pulse, it times out at count 722 when `h_locked` is 1, or at 628 or 528 when it is 0.
- R6: At each field end, the 2-bit confidence level `norm_level` steps up, saturating at 3, if a pulse start fell inside the side's window during the field. Otherwise it steps down, saturating at 0.
- R7: For a field that ends in NORM, WAIT or NEAR, a correct field that directly follows an incorrect one steps the level down.
- R8: With `force_field`=1 the side is 60 Hz when `force_50`=0 and 50 Hz when `force_50`=1. In auto mode, a NONORM pulse return selects 60 Hz when the count is below 578 and 50 Hz otherwise. A NONORM timeout selects the `force_50` side. A side change clears the level to 0. `field_60`=1 means 60 Hz.
- R9: `va_out` is 1 for the first 5 half-lines (50 Hz) or 6 half-lines (60 Hz) after the counter is cleared, while in COUNT.
- R10: `va_oe` is 0 whenever `search_tune` is 1, and 1 otherwise.
- R11: After reset the controller is in COUNT with count 0, level 0, the 50 Hz side and `va_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hl_en | input | 1 | Half-line enable, two per video line |
| vsync_in | input | 1 | Separated vertical sync level |
| h_locked | input | 1 | Horizontal loop lock flag |
| force_field | input | 1 | 1 = side forced by `force_50` |
| force_50 | input | 1 | Forced or fallback side: 1 = 50 Hz, 0 = 60 Hz |
| search_tune | input | 1 | Search-tuning mode, removes VA drive |
| va_out | output | 1 | Vertical drive pulse |
| va_oe | output | 1 | Output enable for `va_out` |
| field_60 | output | 1 | Field side indication, 1 = 60 Hz |
| norm_level | output | 2 | Confidence level |
| ctl_state | output | 3 | Controller state code |

## Verification
A regular 628 half-line pulse train shows the climb from open search through windowed capture to flywheel, and fixes the flywheel period and the pulse width. Dropping a single pulse while in flywheel separates the first-good-counts-as-bad rule from plain up/down counting: the level must fall to 1 instead of returning at once. Removing the pulses entirely, with and without horizontal lock and with either fallback side, tells the 723, 629 and 529 half-line timeout periods apart. A 528 half-line train in auto and in forced-50 mode shows automatic side choice against forcing.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

    typedef enum logic [2:0] {
        ST_COUNT  = 3'd0,
        ST_NORM   = 3'd1,
        ST_NEAR   = 3'd2,
        ST_NONORM = 3'd3,
        ST_WAIT   = 3'd4
    } vd_state_e;

    // Map confidence level to the post-decision state: top -> flywheel,
    // one below top -> windowed, anything lower -> open search.
    function automatic vd_state_e pick_mode(input int unsigned lvl, input int unsigned top);
        if (lvl == top)
            return ST_NORM;
        else if (lvl + 1 == top)
            return ST_NEAR;
        else
            return ST_NONORM;
    endfunction

endpackage

// File: rtl/vdiv_line_cnt.sv
module vdiv_line_cnt #(
    parameter int LC_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hl_en,
    input  logic            clr,
    output logic [LC_W-1:0] lc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lc <= '0;
        else if (hl_en)
            lc <= clr ? '0 : lc + 1'b1;
    end

    // R1: counter frozen between enables
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hl_en |=> $stable(lc));

    // R1: one step per enable when not cleared
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_en && !clr) |=> (lc == $past(lc) + 1'b1));

endmodule

// File: rtl/vdiv_norm_cnt.sv
module vdiv_norm_cnt #(
    parameter int NW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          good,
    input  logic          strict,
    input  logic          side_chg,
    output logic [NW-1:0] nrm
);

    localparam logic [NW-1:0] NMAX = {NW{1'b1}};

    logic prev_bad;
    logic good_eff;

    always_comb good_eff = good && !(strict && prev_bad);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nrm      <= '0;
            prev_bad <= 1'b0;
        end else if (upd) begin
            if (side_chg) begin
                nrm      <= '0;
                prev_bad <= 1'b0;
            end else begin
                if (good_eff)
                    nrm <= (nrm == NMAX) ? nrm : nrm + 1'b1;
                else
                    nrm <= (nrm == '0) ? nrm : nrm - 1'b1;
                prev_bad <= !good;
            end
        end
    end

    // R6: level only moves at field ends
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(nrm));

    // R6: no wrap from the top
    a_r6_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !side_chg && nrm == NMAX) |=> (nrm >= NMAX - 1'b1));

    // R6: no wrap from the bottom
    a_r6_sat_bot: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !side_chg && nrm == '0) |=> (nrm <= 1));

    // R7: after a bad field, strict states never raise the level
    a_r7_first_good: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !side_chg && strict && prev_bad) |=> (nrm <= $past(nrm)));

endmodule

// File: rtl/vdiv_fsm.sv
module vdiv_fsm
    import vdiv_pkg::*;
#(
    parameter int LC_W      = 10,
    parameter int NW        = 2,
    parameter int CNT_END   = 488,
    parameter int NORM_50   = 626,
    parameter int NORM_60   = 526,
    parameter int WLO_50    = 622,
    parameter int WHI_50    = 628,
    parameter int WLO_60    = 522,
    parameter int WHI_60    = 528,
    parameter int FALL_50   = 628,
    parameter int FALL_60   = 528,
    parameter int TO_LOCK   = 722,
    parameter int SPLIT     = 578,
    parameter int VA_50     = 5,
    parameter int VA_60     = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hl_en,
    input  logic            sync_start,
    input  logic [LC_W-1:0] lc,
    input  logic [NW-1:0]   nrm,
    input  logic            h_locked,
    input  logic            force_field,
    input  logic            force_50,
    input  logic            search_tune,
    output logic            lc_clr,
    output logic            fld_end,
    output logic            good,
    output logic            strict,
    output logic            side_chg,
    output logic            va_out,
    output logic            va_oe,
    output logic            field_60,
    output vd_state_e       st_o
);

    localparam int unsigned NTOP = (1 << NW) - 1;
    localparam logic [LC_W-1:0] L_CEND = LC_W'(CNT_END);
    localparam logic [LC_W-1:0] L_TO   = LC_W'(TO_LOCK);
    localparam logic [LC_W-1:0] L_SPL  = LC_W'(SPLIT);

    // Side-dependent limits, index 0 = 50 Hz, 1 = 60 Hz.
    logic [LC_W-1:0] lim_norm [2];
    logic [LC_W-1:0] lim_wlo  [2];
    logic [LC_W-1:0] lim_whi  [2];
    logic [LC_W-1:0] lim_fall [2];
    logic [LC_W-1:0] lim_va   [2];

    for (genvar s = 0; s < 2; s++) begin : g_side
        always_comb begin
            lim_norm[s] = LC_W'(s == 0 ? NORM_50 : NORM_60);
            lim_wlo[s]  = LC_W'(s == 0 ? WLO_50  : WLO_60);
            lim_whi[s]  = LC_W'(s == 0 ? WHI_50  : WHI_60);
            lim_fall[s] = LC_W'(s == 0 ? FALL_50 : FALL_60);
            lim_va[s]   = LC_W'(s == 0 ? VA_50   : VA_60);
        end
    end

    vd_state_e st, st_n;
    logic is60, side_n;
    logic pend, pend_n;
    logic win_hit, hit_n;
    logic hit_now, in_win, pulse_ret, tmo;
    logic [LC_W-1:0] norm_end, fall_end, to_lim;

    always_comb begin
        norm_end = lim_norm[is60];
        fall_end = lim_fall[is60];
        to_lim   = h_locked ? L_TO : fall_end;
        in_win   = (lc > lim_wlo[is60]) && (lc < lim_whi[is60]);
        hit_now  = sync_start && in_win;
    end

    // Next-state and control decode
    always_comb begin
        st_n      = st;
        side_n    = is60;
        pend_n    = pend;
        hit_n     = win_hit;
        lc_clr    = 1'b0;
        fld_end   = 1'b0;
        pulse_ret = 1'b0;
        tmo       = 1'b0;
        if (hl_en) begin
            unique case (st)
                ST_COUNT: begin
                    pend_n = 1'b0;
                    lc_clr = pend;
                    if (!pend && lc == L_CEND)
                        st_n = pick_mode(int'(nrm), NTOP);
                end
                ST_NORM: begin
                    if (hit_now)
                        hit_n = 1'b1;
                    if (lc == norm_end)
                        st_n = ST_WAIT;
                end
                ST_WAIT: begin
                    fld_end = 1'b1;
                    lc_clr  = 1'b1;
                    st_n    = ST_COUNT;
                end
                ST_NEAR: begin
                    if (hit_now) begin
                        fld_end = 1'b1;
                        pend_n  = 1'b1;
                        st_n    = ST_COUNT;
                    end else if (lc >= fall_end) begin
                        fld_end = 1'b1;
                        lc_clr  = 1'b1;
                        st_n    = ST_COUNT;
                    end
                end
                ST_NONORM: begin
                    if (sync_start) begin
                        fld_end   = 1'b1;
                        pend_n    = 1'b1;
                        pulse_ret = 1'b1;
                        st_n      = ST_COUNT;
                    end else if (lc >= to_lim) begin
                        fld_end = 1'b1;
                        lc_clr  = 1'b1;
                        tmo     = 1'b1;
                        st_n    = ST_COUNT;
                    end
                end
                default: st_n = ST_COUNT;
            endcase
            if (fld_end) begin
                hit_n = 1'b0;
                if (force_field)
                    side_n = !force_50;
                else if (pulse_ret)
                    side_n = (lc < L_SPL);
                else if (tmo)
                    side_n = !force_50;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_COUNT;
            is60    <= 1'b0;
            pend    <= 1'b0;
            win_hit <= 1'b0;
        end else begin
            st      <= st_n;
            is60    <= side_n;
            pend    <= pend_n;
            win_hit <= hit_n;
        end
    end

    // Outputs
    always_comb begin
        good     = win_hit || hit_now;
        strict   = (st == ST_NORM) || (st == ST_WAIT) || (st == ST_NEAR);
        side_chg = fld_end && (side_n != is60);
        va_out   = (st == ST_COUNT) && !pend && (lc < lim_va[is60]);
        va_oe    = !search_tune;
        field_60 = is60;
        st_o     = st;
    end

    // R1: state frozen between enables
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hl_en |=> $stable(st));

    // R2: decision count always leaves COUNT
    a_r2_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT && hl_en && !pend && lc == L_CEND) |=> (st != ST_COUNT));

    // R3: WAIT lasts exactly one enable
    a_r3_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && hl_en) |=> (st == ST_COUNT));

    // R4: windowed state never passes its fallback count
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NEAR) |-> (lc <= fall_end));

    // R5: open search never passes the locked timeout
    a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NONORM) |-> (lc <= L_TO));

    // R9: drive pulse only at the start of COUNT
    a_r9_va_early: assert property (@(posedge clk) disable iff (!rst_n)
        va_out |-> (lc <= lim_va[1]));

endmodule

// File: rtl/vdiv_ctrl.sv
module vdiv_ctrl
    import vdiv_pkg::*;
#(
    parameter int NW        = 2,
    parameter int CNT_END   = 488,
    parameter int NORM_50   = 626,
    parameter int NORM_60   = 526,
    parameter int WLO_50    = 622,
    parameter int WHI_50    = 628,
    parameter int WLO_60    = 522,
    parameter int WHI_60    = 528,
    parameter int FALL_50   = 628,
    parameter int FALL_60   = 528,
    parameter int TO_LOCK   = 722,
    parameter int SPLIT     = 578,
    parameter int VA_50     = 5,
    parameter int VA_60     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hl_en,
    input  logic          vsync_in,
    input  logic          h_locked,
    input  logic          force_field,
    input  logic          force_50,
    input  logic          search_tune,
    output logic          va_out,
    output logic          va_oe,
    output logic          field_60,
    output logic [NW-1:0] norm_level,
    output logic [2:0]    ctl_state
);

    localparam int LC_W = $clog2(TO_LOCK + 2);

    logic            vs_prev;
    logic            sync_start;
    logic [LC_W-1:0] lc;
    logic            lc_clr, fld_end, good, strict, side_chg;
    vd_state_e       st;

    // Sync pulse start, sampled on the half-line grid
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vs_prev <= 1'b0;
        else if (hl_en)
            vs_prev <= vsync_in;
    end

    always_comb sync_start = hl_en && vsync_in && !vs_prev;

    vdiv_line_cnt #(.LC_W(LC_W)) u_lc (
        .clk   (clk),
        .rst_n (rst_n),
        .hl_en (hl_en),
        .clr   (lc_clr),
        .lc    (lc)
    );

    vdiv_norm_cnt #(.NW(NW)) u_nc (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (fld_end),
        .good     (good),
        .strict   (strict),
        .side_chg (side_chg),
        .nrm      (norm_level)
    );

    vdiv_fsm #(
        .LC_W(LC_W), .NW(NW), .CNT_END(CNT_END),
        .NORM_50(NORM_50), .NORM_60(NORM_60),
        .WLO_50(WLO_50), .WHI_50(WHI_50), .WLO_60(WLO_60), .WHI_60(WHI_60),
        .FALL_50(FALL_50), .FALL_60(FALL_60), .TO_LOCK(TO_LOCK),
        .SPLIT(SPLIT), .VA_50(VA_50), .VA_60(VA_60)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hl_en       (hl_en),
        .sync_start  (sync_start),
        .lc          (lc),
        .nrm         (norm_level),
        .h_locked    (h_locked),
        .force_field (force_field),
        .force_50    (force_50),
        .search_tune (search_tune),
        .lc_clr      (lc_clr),
        .fld_end     (fld_end),
        .good        (good),
        .strict      (strict),
        .side_chg    (side_chg),
        .va_out      (va_out),
        .va_oe       (va_oe),
        .field_60    (field_60),
        .st_o        (st)
    );

    always_comb ctl_state = st;

    // R10: drive disabled in search-tuning mode
    a_r10_oe: assert property (@(posedge clk) disable iff (!rst_n)
        search_tune |-> !va_oe);

endmodule

// File: tb/vdiv_ctrl_bench.sv
`timescale 1ns/1ps
module vdiv_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hl_en = 1'b0;
    logic vsync_in = 1'b0;
    logic h_locked = 1'b1;
    logic force_field = 1'b0;
    logic force_50 = 1'b1;
    logic search_tune = 1'b0;
    logic va_out, va_oe, field_60;
    logic [1:0] norm_level;
    logic [2:0] ctl_state;

    always #2 clk = ~clk;

    vdiv_ctrl u_vdiv_ctrl (
        .clk(clk), .rst_n(rst_n), .hl_en(hl_en), .vsync_in(vsync_in),
        .h_locked(h_locked), .force_field(force_field), .force_50(force_50),
        .search_tune(search_tune), .va_out(va_out), .va_oe(va_oe),
        .field_60(field_60), .norm_level(norm_level), .ctl_state(ctl_state)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st, m_lc, m_nrm, m_60, hl_count;
    bit m_pb, m_pend, m_hit, m_vp;

    always @(posedge clk) begin
        int lo, hi, ne, fe, tl, nlc, nst, n60;
        bit ss, inw, fend, good, pret, tout, npend, strict;
        if (!rst_n) begin
            m_st = 0; m_lc = 0; m_nrm = 0; m_pb = 0; m_pend = 0;
            m_hit = 0; m_60 = 0; m_vp = 0; hl_count = 0;
        end else if (hl_en) begin
            hl_count++;
            ss = vsync_in && !m_vp;
            m_vp = vsync_in;
            if (m_60 != 0) begin lo = 522; hi = 528; ne = 526; fe = 528; end
            else           begin lo = 622; hi = 628; ne = 626; fe = 628; end
            tl = h_locked ? 722 : fe;
            inw = ss && (m_lc > lo) && (m_lc < hi);
            fend = 0; good = 0; pret = 0; tout = 0;
            nlc = m_lc + 1; nst = m_st; npend = m_pend;
            case (m_st)
                0: begin
                    npend = 0;
                    if (m_pend) nlc = 0;
                    else if (m_lc == 488) nst = (m_nrm == 3) ? 1 : (m_nrm == 2) ? 2 : 3;
                end
                1: begin
                    if (inw) m_hit = 1;
                    if (m_lc == ne) nst = 4;
                end
                4: begin fend = 1; good = m_hit || inw; nst = 0; nlc = 0; end
                2: begin
                    if (inw) begin fend = 1; good = 1; nst = 0; npend = 1; end
                    else if (m_lc >= fe) begin fend = 1; nst = 0; nlc = 0; end
                end
                default: begin
                    if (ss) begin fend = 1; good = inw; nst = 0; npend = 1; pret = 1; end
                    else if (m_lc >= tl) begin fend = 1; nst = 0; nlc = 0; tout = 1; end
                end
            endcase
            if (fend) begin
                strict = (m_st == 1) || (m_st == 4) || (m_st == 2);
                if (force_field) n60 = !force_50;
                else if (pret) n60 = (m_lc < 578);
                else if (tout) n60 = !force_50;
                else n60 = m_60;
                if (n60 != m_60) begin m_nrm = 0; m_pb = 0; end
                else begin
                    if (good && !(strict && m_pb)) m_nrm = (m_nrm < 3) ? m_nrm + 1 : 3;
                    else m_nrm = (m_nrm > 0) ? m_nrm - 1 : 0;
                    m_pb = !good;
                end
                m_60 = n60;
                m_hit = 0;
            end
            m_st = nst; m_lc = nlc; m_pend = npend;
        end
    end

    // ---------------- stimulus, comparison, measurement ----------------
    bit hl_run = 0;
    bit sync_on = 0;
    bit skip_one = 0;
    bit skipping = 0;
    int period = 628;
    int ph = 0;
    int hcnt = 0, last_rise = 0, va_period = 0, va_run = 0, va_width = 0;
    int min_nrm = 3;
    bit va_q = 0;
    bit seen [5];

    always @(negedge clk) begin
        int exp_va;
        if (rst_n && !done) begin
            exp_va = (m_st == 0 && !m_pend && m_lc < ((m_60 != 0) ? 6 : 5)) ? 1 : 0;
            check(va_out == exp_va, "R9 va_out", va_out, exp_va);
            check(va_oe == !search_tune, "R10 va_oe", va_oe, !search_tune);
            check(field_60 == m_60, "R8 field_60", field_60, m_60);
            check(norm_level == m_nrm, "R6 R7 norm_level", norm_level, m_nrm);
            check(ctl_state == m_st, "R2 R3 R4 R5 ctl_state", ctl_state, m_st);
            if (hl_en) begin
                hcnt++;
                if (va_out && !va_q) begin
                    va_period = hcnt - last_rise; last_rise = hcnt; va_run = 1;
                end else if (va_out) va_run++;
                if (!va_out && va_q) va_width = va_run;
                va_q = va_out;
                if (ctl_state < 5) seen[ctl_state] = 1;
                if (norm_level < min_nrm) min_nrm = norm_level;
            end
        end
        if (hl_run && !hl_en) begin
            hl_en = 1;
            if (sync_on) begin
                ph = (ph + 1) % period;
                if (ph == 0) begin
                    skipping = skip_one;
                    skip_one = 0;
                end
                vsync_in = !skipping && (ph < 5);
            end else begin
                vsync_in = 0;
            end
        end else begin
            hl_en = 0;
        end
    end

    task automatic wait_hl(input int n);
        int target;
        target = hl_count + n;
        while (hl_count < target) @(negedge clk);
    endtask

    task automatic clear_seen();
        for (int i = 0; i < 5; i++) seen[i] = 0;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s_st, s_nrm, s_va;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check(ctl_state == 0, "R11 reset state", ctl_state, 0);
        check(norm_level == 0, "R11 reset level", norm_level, 0);
        check(field_60 == 0, "R11 reset side", field_60, 0);
        check(va_out == 1, "R11 reset va", va_out, 1);
        check(va_oe == 1, "R10 oe default", va_oe, 1);

        // R1: no enables, nothing moves
        s_st = ctl_state; s_nrm = norm_level; s_va = va_out;
        repeat (20) @(negedge clk);
        check(ctl_state == s_st && va_out == s_va && norm_level == s_nrm,
              "R1 idle hold", ctl_state, s_st);

        // 50 Hz regular pulses: climb to flywheel
        hl_run = 1; sync_on = 1; period = 628;
        clear_seen();
        wait_hl(10000);
        check(norm_level == 3, "R6 level saturates", norm_level, 3);
        check(seen[1] == 1, "R2 NORM reached", seen[1], 1);
        check(seen[3] == 1, "R2 NONORM used", seen[3], 1);
        check(field_60 == 0, "R8 auto 50", field_60, 0);
        check(va_period == 628, "R3 flywheel 50 period", va_period, 628);
        check(va_width == 5, "R9 width 50", va_width, 5);

        // R7: drop one pulse in flywheel
        clear_seen(); min_nrm = 3; skip_one = 1;
        wait_hl(4000);
        check(min_nrm == 1, "R7 first good counted bad", min_nrm, 1);
        check(seen[2] == 1, "R4 NEAR visited", seen[2], 1);
        check(norm_level == 3, "R6 recovers", norm_level, 3);

        // R5: no pulses, locked then unlocked
        sync_on = 0; clear_seen();
        wait_hl(4000);
        check(seen[3] == 1, "R5 NONORM reached", seen[3], 1);
        check(va_period == 723, "R5 locked timeout", va_period, 723);
        h_locked = 0;
        wait_hl(2500);
        check(va_period == 629, "R5 unlocked timeout", va_period, 629);

        // R8: auto fallback to the force_50=0 side
        force_50 = 0;
        wait_hl(2500);
        check(field_60 == 1, "R8 fallback 60", field_60, 1);
        check(va_period == 529, "R5 unlocked timeout 60", va_period, 529);

        // 60 Hz pulses, auto
        force_50 = 1; h_locked = 1; period = 528; sync_on = 1;
        wait_hl(7000);
        check(field_60 == 1, "R8 auto picks 60", field_60, 1);
        check(norm_level == 3, "R6 level 60", norm_level, 3);
        check(va_period == 528, "R3 flywheel 60 period", va_period, 528);
        check(va_width == 6, "R9 width 60", va_width, 6);

        // forced 50 with 60 Hz input
        force_field = 1; force_50 = 1;
        wait_hl(3000);
        check(field_60 == 0, "R8 forced 50", field_60, 0);
        force_50 = 0;
        wait_hl(2000);
        check(field_60 == 1, "R8 forced 60", field_60, 1);

        // R10
        search_tune = 1;
        repeat (3) @(negedge clk);
        check(va_oe == 0, "R10 search tune", va_oe, 0);
        search_tune = 0;
        repeat (3) @(negedge clk);
        check(va_oe == 1, "R10 restore", va_oe, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule